// File: doc/BRIEF.md
# Word-to-line AXI4 memory bridge

This block lets a core that issues 32-bit word loads and stores reach a memory that speaks AXI4 with a data bus one 32-byte line wide. Each core request becomes exactly one single-beat AXI4 transaction at the line-aligned address. On a read, the wanted word is picked out of the returned line by its slot index. On a write, the word is placed on the wide data bus and only its four byte strobes are raised.

The bridge handles one transaction at a time. The core raises a read or write strobe for one cycle while the bridge is idle, and the bridge shows busy until the access finishes. The bridge then pulses an ack for one cycle. For a read, the word is valid in that ack cycle. It then stays unchanged until the core makes its next request, so a consumer may sample it late. The address bus and the raw AXI read bus may change freely while the read word is held.

Top module: `core_axi_line_bridge`

## Requirements
- R1: Address bits [1:0] are ignored. A word written with any low bits set is read back at the same word with other low bits.
- R2: A request is taken only while the bridge is idle. Strobes raised while busy have no effect on memory, on the data returned or on the ack count. If read and write strobes are raised together, the write is performed.
- R3: Every AXI transaction is a single beat: ARLEN and AWLEN are 0, size code 5 (32 bytes), burst type INCR (1), WLAST is 1. ARADDR and AWADDR equal the request address with bits [4:0] cleared.
- R4: A read returns the 32-bit word at byte offset 4*addr[4:2] of the returned line (slot 0 in RDATA[31:0]). All 8 slots are independent.
- R5: A write drives the word on WDATA bits [32*s+31:32*s] for slot s = addr[4:2]. WSTRB has exactly bits [4*s+3:4*s] set.
- R6: core_ack is high for exactly one cycle per accepted request. For a read, core_rd_data carries the read word in that cycle.
- R7: After an ack, core_rd_data stays bit-identical on every cycle until the next request is sampled. This holds whatever core_addr and the AXI read data bus do.
- R8: core_busy is high from the cycle after a request is accepted through the ack cycle, and low otherwise. Ack is low while idle.
- R9: ARVALID, AWVALID and WVALID stay high, with address and data stable, until their ready is seen. RREADY and BREADY are high only while the bridge waits for that response.
- R10: Reset clears busy, ack, core_rd_data and all AXI valid and ready outputs.
- R11: A read is acked only after its R handshake, and a write only after its B handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_addr | input | ADDR_W | Byte address of the word |
| core_rd_req | input | 1 | Read request strobe |
| core_wr_req | input | 1 | Write request strobe |
| core_wr_data | input | 32 | Word to store |
| core_rd_data | output | 32 | Held read word |
| core_busy | output | 1 | Access in progress |
| core_ack | output | 1 | One-cycle completion pulse |
| m_araddr | output | ADDR_W | Read address, line aligned |
| m_arlen | output | 8 | Burst length, always 0 |
| m_arsize | output | 3 | Beat size code |
| m_arburst | output | 2 | Burst type |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 256 | Read line |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_awaddr | output | ADDR_W | Write address, line aligned |
| m_awlen | output | 8 | Burst length, always 0 |
| m_awsize | output | 3 | Beat size code |
| m_awburst | output | 2 | Burst type |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 256 | Write line |
| m_wstrb | output | 32 | Byte strobes |
| m_wlast | output | 1 | Last beat, always 1 |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |

## Verification
The slave model uses random ready and response delays, and it drives random garbage on the read data bus whenever the bus is not valid. A held word that leaks from the raw bus therefore shows up at once. Random reads and writes over 64 lines and all slots, with random low address bits and random idle gaps, are compared with a reference word array. They expose slot decoding, strobe placement and ignored-bit errors. The address is scrambled every idle cycle, which separates a truly registered read word from one that depends on the address. Directed cases cover these points:
- a full line of writes followed by reads of every slot;
- strobes raised while busy, and both strobes raised together, which show whether a request is dropped and which strobe wins.

// File: rtl/core_axi_line_bridge.sv
module core_axi_line_bridge #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       core_addr,
  input  logic                    core_rd_req,
  input  logic                    core_wr_req,
  input  logic [WORD_BYTES*8-1:0] core_wr_data,
  output logic [WORD_BYTES*8-1:0] core_rd_data,
  output logic                    core_busy,
  output logic                    core_ack,
  output logic [ADDR_W-1:0]       m_araddr,
  output logic [7:0]              m_arlen,
  output logic [2:0]              m_arsize,
  output logic [1:0]              m_arburst,
  output logic                    m_arvalid,
  input  logic                    m_arready,
  input  logic [LINE_BYTES*8-1:0] m_rdata,
  input  logic                    m_rvalid,
  output logic                    m_rready,
  output logic [ADDR_W-1:0]       m_awaddr,
  output logic [7:0]              m_awlen,
  output logic [2:0]              m_awsize,
  output logic [1:0]              m_awburst,
  output logic                    m_awvalid,
  input  logic                    m_awready,
  output logic [LINE_BYTES*8-1:0] m_wdata,
  output logic [LINE_BYTES-1:0]   m_wstrb,
  output logic                    m_wlast,
  output logic                    m_wvalid,
  input  logic                    m_wready,
  input  logic                    m_bvalid,
  output logic                    m_bready
);
  localparam int WORD_W = WORD_BYTES * 8;
  localparam int SLOTS  = LINE_BYTES / WORD_BYTES;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int WOFS_W = $clog2(WORD_BYTES);
  localparam int LOFS_W = $clog2(LINE_BYTES);
  localparam int HI_W   = ADDR_W - LOFS_W;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_RESP, S_ACK} st_t;

  st_t               st;
  logic              is_wr;
  logic [HI_W-1:0]   line_hi;
  logic [SLOT_W-1:0] slot;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;
  logic              accept;
  logic              unused_lo;

  assign unused_lo = ^core_addr[WOFS_W-1:0];
  assign accept    = (st == S_IDLE) && (core_rd_req || core_wr_req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      is_wr   <= 1'b0;
      line_hi <= '0;
      slot    <= '0;
      wr_word <= '0;
      rd_word <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          is_wr   <= core_wr_req;
          line_hi <= core_addr[ADDR_W-1:LOFS_W];
          slot    <= core_addr[LOFS_W-1:WOFS_W];
          wr_word <= core_wr_data;
          st      <= S_ADDR;
        end
        S_ADDR: if (is_wr ? m_awready : m_arready) st <= is_wr ? S_DATA : S_RESP;
        S_DATA: if (m_wready) st <= S_RESP;
        S_RESP: begin
          if (is_wr && m_bvalid) st <= S_ACK;
          if (!is_wr && m_rvalid) begin
            rd_word <= m_rdata[slot*WORD_W +: WORD_W];
            st      <= S_ACK;
          end
        end
        S_ACK:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign core_rd_data = rd_word;
  assign core_busy    = (st != S_IDLE);
  assign core_ack     = (st == S_ACK);

  assign m_araddr  = {line_hi, {LOFS_W{1'b0}}};
  assign m_awaddr  = {line_hi, {LOFS_W{1'b0}}};
  assign m_arlen   = 8'd0;
  assign m_awlen   = 8'd0;
  assign m_arsize  = 3'(LOFS_W);
  assign m_awsize  = 3'(LOFS_W);
  assign m_arburst = 2'b01;
  assign m_awburst = 2'b01;
  assign m_wlast   = 1'b1;
  assign m_arvalid = (st == S_ADDR) && !is_wr;
  assign m_awvalid = (st == S_ADDR) && is_wr;
  assign m_wvalid  = (st == S_DATA);
  assign m_rready  = (st == S_RESP) && !is_wr;
  assign m_bready  = (st == S_RESP) && is_wr;

  for (genvar g = 0; g < SLOTS; g++) begin : g_lane
    assign m_wdata[g*WORD_W +: WORD_W]         = wr_word;
    assign m_wstrb[g*WORD_BYTES +: WORD_BYTES] = (slot == SLOT_W'(g)) ? '1 : '0;
  end
endmodule

module core_axi_line_bridge_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [WORD_BYTES*8-1:0] core_rd_data,
  input logic                    core_busy,
  input logic                    core_ack,
  input logic [ADDR_W-1:0]       m_araddr,
  input logic [7:0]              m_arlen,
  input logic                    m_arvalid,
  input logic                    m_arready,
  input logic                    m_rvalid,
  input logic                    m_rready,
  input logic [ADDR_W-1:0]       m_awaddr,
  input logic                    m_awvalid,
  input logic                    m_awready,
  input logic [LINE_BYTES-1:0]   m_wstrb,
  input logic                    m_wvalid,
  input logic                    m_wready,
  input logic                    m_bready
);
  localparam int LOFS_W = $clog2(LINE_BYTES);

  AST_RD_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(m_rvalid && m_rready) |-> $stable(core_rd_data)); // R7
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    core_ack |=> !core_ack); // R6
  AST_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    core_ack |-> core_busy); // R8
  AST_AR_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> (m_arlen == 8'd0) && (m_araddr[LOFS_W-1:0] == '0)); // R3
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr)); // R9
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr)); // R9
  AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wstrb)); // R9
  AST_RESP_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rready || m_bready) |-> core_busy); // R9
  AST_STRB_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid |-> $countones(m_wstrb) == WORD_BYTES); // R5
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m_arvalid, m_awvalid, m_wvalid})); // R2
endmodule

bind core_axi_line_bridge core_axi_line_bridge_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)
) chk_i (.*);

// File: tb/core_axi_line_bridge_tb_top.sv
`timescale 1ns/1ps
module core_axi_line_bridge_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0]  core_addr = '0, core_wr_data = '0;
  logic         core_rd_req = 1'b0, core_wr_req = 1'b0;
  logic [31:0]  core_rd_data;
  logic         core_busy, core_ack;
  logic [31:0]  m_araddr, m_awaddr;
  logic [7:0]   m_arlen, m_awlen;
  logic [2:0]   m_arsize, m_awsize;
  logic [1:0]   m_arburst, m_awburst;
  logic         m_arvalid, m_arready, m_rvalid, m_rready;
  logic         m_awvalid, m_awready, m_wlast, m_wvalid, m_wready, m_bvalid, m_bready;
  logic [255:0] m_rdata, m_wdata;
  logic [31:0]  m_wstrb;

  core_axi_line_bridge dut_i (.*);

  int nchk = 0, nfail = 0;
  int r_hs = 0, b_hs = 0;
  logic [31:0] cur_addr = '0, cur_data = '0;
  logic [31:0] ref_mem [512];
  logic [255:0] mem [64];

  function automatic logic [31:0] seed_word(int l, int s);
    return (32'(l * 8 + s) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction
  function automatic logic [255:0] rnd_line();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction
  function automatic logic [31:0] exp_strb(logic [31:0] a);
    return 32'hF << (4 * a[4:2]);
  endfunction
  function automatic int widx(logic [31:0] a);
    return int'(a[10:2]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic       rpend, bpend, ar_stall, w_stall;
  logic [1:0] rwait, bwait;
  logic [5:0] rline, wline;
  logic [31:0] ar_prev, w_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_arready <= 0; m_awready <= 0; m_wready <= 0;
      m_rvalid <= 0; m_bvalid <= 0; rpend <= 0; bpend <= 0;
      ar_stall <= 0; w_stall <= 0; m_rdata <= '0;
      rwait <= 0; bwait <= 0; rline <= 0; wline <= 0; ar_prev <= 0; w_prev <= 0;
      for (int l = 0; l < 64; l++)
        for (int s = 0; s < 8; s++) mem[l][s*32 +: 32] <= seed_word(l, s);
    end else begin
      m_arready <= 1'($urandom); m_awready <= 1'($urandom); m_wready <= 1'($urandom);
      if (ar_stall) chk(m_arvalid && m_araddr == ar_prev, "R9 ARVALID held", m_araddr, ar_prev);
      if (w_stall)  chk(m_wvalid && m_wstrb == w_prev, "R9 WVALID held", m_wstrb, w_prev);
      ar_stall <= m_arvalid && !m_arready; ar_prev <= m_araddr;
      w_stall  <= m_wvalid && !m_wready;   w_prev  <= m_wstrb;
      if ((m_rready && !rpend && !m_rvalid) || (m_bready && !bpend && !m_bvalid) || ((m_rready || m_bready) && !core_busy))
        chk(0, "R9 ready outside response wait", {m_rready, m_bready}, 0);
      if (m_arvalid && m_arready) begin
        chk(m_arlen == 0 && m_arsize == 3'd5 && m_arburst == 2'b01, "R3 AR beat fields", {m_arlen, m_arsize, m_arburst}, {8'd0, 3'd5, 2'b01});
        chk(m_araddr == {cur_addr[31:5], 5'b0}, "R3 ARADDR", m_araddr, {cur_addr[31:5], 5'b0});
        rpend <= 1; rline <= m_araddr[10:5]; rwait <= 2'($urandom);
      end
      if (m_awvalid && m_awready) begin
        chk(m_awlen == 0 && m_awsize == 3'd5 && m_awburst == 2'b01, "R3 AW beat fields", {m_awlen, m_awsize, m_awburst}, {8'd0, 3'd5, 2'b01});
        chk(m_awaddr == {cur_addr[31:5], 5'b0}, "R3 AWADDR", m_awaddr, {cur_addr[31:5], 5'b0});
        wline <= m_awaddr[10:5];
      end
      if (m_wvalid && m_wready) begin
        chk(m_wlast, "R3 WLAST", m_wlast, 1);
        chk(m_wstrb == exp_strb(cur_addr), "R5 WSTRB", m_wstrb, exp_strb(cur_addr));
        chk(m_wdata[cur_addr[4:2]*32 +: 32] == cur_data, "R5 WDATA lane", m_wdata[cur_addr[4:2]*32 +: 32], cur_data);
        for (int b = 0; b < 32; b++) if (m_wstrb[b]) mem[wline][b*8 +: 8] <= m_wdata[b*8 +: 8];
        bpend <= 1; bwait <= 2'($urandom);
      end
      if (m_rvalid && m_rready) begin
        m_rvalid <= 0; rpend <= 0; r_hs++; m_rdata <= rnd_line();
      end else if (rpend && !m_rvalid) begin
        if (rwait == 0) begin m_rvalid <= 1; m_rdata <= mem[rline]; end
        else begin rwait <= rwait - 1; m_rdata <= rnd_line(); end
      end else if (!m_rvalid) m_rdata <= rnd_line();
      if (m_bvalid && m_bready) begin
        m_bvalid <= 0; bpend <= 0; b_hs++;
      end else if (bpend && !m_bvalid) begin
        if (bwait == 0) m_bvalid <= 1; else bwait <= bwait - 1;
      end
    end
  end

  // mode: 0 normal, 1 intrude with a write while busy, 2 intrude with a read while busy
  task automatic access(input bit wr, input bit rd, input logic [31:0] a, input logic [31:0] d,
                        input int idle, input int mode, output logic [31:0] got);
    int r0, b0;
    bit seen;
    logic [31:0] held;
    @(negedge clk);
    core_addr = a; core_rd_req = rd; core_wr_req = wr; core_wr_data = d;
    cur_addr = a; cur_data = d; r0 = r_hs; b0 = b_hs;
    @(negedge clk);
    core_rd_req = 0; core_wr_req = 0; core_addr = $urandom; core_wr_data = $urandom;
    if (mode == 1) begin core_wr_req = 1; core_addr = a; core_wr_data = ~d; end
    if (mode == 2) begin core_rd_req = 1; core_addr = a ^ 32'h20; end
    chk(core_busy, "R8 busy after accept", core_busy, 1);
    chk(!core_ack, "R8 no ack right after accept", core_ack, 0);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      if (i == 1) begin core_rd_req = 0; core_wr_req = 0; end
      if (core_ack) begin seen = 1; break; end
      chk(core_busy, "R8 busy during access", core_busy, 1);
      @(negedge clk);
      core_addr = $urandom;
    end
    core_rd_req = 0; core_wr_req = 0;
    chk(seen, "R6 ack arrives", seen, 1);
    got = core_rd_data; held = core_rd_data;
    if (wr) begin
      chk(b_hs == b0 + 1 && r_hs == r0, "R11 write ack after B", {b_hs - b0, r_hs - r0}, {32'd1, 32'd0});
      ref_mem[widx(a)] = d;
    end else begin
      chk(r_hs == r0 + 1 && b_hs == b0, "R11 read ack after R", {r_hs - r0, b_hs - b0}, {32'd1, 32'd0});
      chk(got == ref_mem[widx(a)], "R4 read word at ack", got, ref_mem[widx(a)]);
    end
    for (int i = 0; i <= idle; i++) begin
      @(negedge clk);
      chk(core_rd_data == held, "R7 rd_data held", core_rd_data, held);
      chk(!core_ack, i == 0 ? "R6 ack one cycle" : "R8 ack low idle", core_ack, 0);
      chk(!core_busy, "R8 busy low idle", core_busy, 0);
      core_addr = $urandom;
    end
  endtask

  initial begin
    logic [31:0] got, base;
    void'($urandom(32'h00C0FFEE));
    for (int l = 0; l < 64; l++)
      for (int s = 0; s < 8; s++) ref_mem[l*8 + s] = seed_word(l, s);
    repeat (3) @(negedge clk);
    chk(!core_busy && !core_ack && core_rd_data == 0, "R10 reset outputs", {core_busy, core_ack, core_rd_data}, 0);
    chk(!m_arvalid && !m_awvalid && !m_wvalid && !m_rready && !m_bready, "R10 reset AXI",
        {m_arvalid, m_awvalid, m_wvalid, m_rready, m_bready}, 0);
    rst_n = 1;
    @(negedge clk);

    base = 32'h0000_0140;
    for (int s = 0; s < 8; s++) access(1, 0, base + 32'(4*s), 32'hC0DE_0000 + 32'(s), 0, 0, got);
    for (int s = 7; s >= 0; s--) access(0, 1, base + 32'(4*s), 0, 2, 0, got); // R4 all slots
    access(1, 0, 32'h0000_0263, 32'hDEADBEEF, 1, 0, got);
    access(0, 1, 32'h0000_0260, 0, 1, 0, got);
    chk(got == 32'hDEADBEEF, "R1 low bits ignored", got, 32'hDEADBEEF);
    access(0, 1, 32'h0000_0262, 0, 8, 0, got);
    chk(got == 32'hDEADBEEF, "R1 low bits ignored on read", got, 32'hDEADBEEF);
    access(0, 1, 32'h0000_0100, 0, 8, 1, got);
    chk(got == seed_word(8, 0), "R2 dropped write has no effect", got, seed_word(8, 0));
    access(0, 1, 32'h0000_0100, 0, 3, 2, got);
    chk(got == seed_word(8, 0), "R2 memory unchanged after dropped write", got, seed_word(8, 0));
    access(1, 1, 32'h0000_0304, 32'h1234_5678, 2, 0, got);
    access(0, 1, 32'h0000_0304, 0, 2, 0, got);
    chk(got == 32'h1234_5678, "R2 write wins when both strobes", got, 32'h1234_5678);

    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      bit w;
      a = {21'd0, 11'($urandom)};
      w = 1'($urandom);
      access(w, !w, a, $urandom, int'($urandom_range(0, 5)), 0, got);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule